// File: doc/BRIEF.md
# Single-Precision Compare and Sign Unit

This block carries out the simple single-precision floating-point operations that need no arithmetic datapath. On a compare it orders two IEEE-754 single-precision words, reports the outcome as a two-bit condition code aimed at condition set zero, and raises the invalid-operation flag when the rules call for it. On a sign operation it copies, negates or clears the sign of the second operand by working on the raw bits, without looking at what the bits encode.

Each operation is presented for one cycle with `in_valid` high. The registered results appear on the next clock edge along with `out_valid`. A compare also pulses `cc_we` so that the surrounding status logic can load the code into its condition field at bits 11:10. The code is always written to set zero.

Top module: `sp_cmp_sign_unit`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `out_valid`, `result`, `cc`, `cc_we` and `exc_flags` are all zero.
- R2: `out_valid` is high exactly one cycle after a cycle with `in_valid` high. `cc_we` and `exc_flags` are zero on any cycle where `out_valid` is zero. `result` and `cc` keep their values when no operation is accepted.
- R3: The operation codes are 0 for the quiet compare, 1 for the signalling compare, 2 for move, 3 for negate and 4 for absolute value. A compare pulses `cc_we`, drives `result` to zero and sets `cc` to 0 when `src_a` equals `src_b`, 1 when `src_a` < `src_b`, 2 when `src_a` > `src_b` and 3 when the pair is unordered.
- R4: +0 and -0 compare equal in every sign combination, giving code 0.
- R5: Ordered operands are ranked by sign and magnitude. A negative value is below every positive value, and of two negative values the one with the larger magnitude is the lesser.
- R6: A word whose exponent bits 30:23 are all ones and whose fraction bits 22:0 are not zero is a NaN. Any NaN operand makes a compare unordered (code 3).
- R7: `exc_flags` is five bits with invalid at bit 4, and bits 3:0 are never set by this block. A quiet compare raises invalid only when it is unordered and at least one operand is a signalling NaN, meaning a NaN with fraction bit 22 clear.
- R8: A signalling compare raises invalid whenever the result is unordered, including when both operands are quiet NaNs.
- R9: Move returns `src_b` unchanged. Negate returns `src_b` with bit 31 inverted. Absolute value returns `src_b` with bit 31 cleared.
- R10: Move, negate and absolute value never raise a flag and never pulse `cc_we`, even when `src_b` or `src_a` is a NaN, and they leave `cc` unchanged.
- R11: Operation codes 5 to 7 produce `out_valid` with `result` zero, no `cc_we`, no flags and `cc` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| op_sel | input | 3 | Operation code (see R3) |
| src_a | input | 32 | First operand (left side of the compare) |
| src_b | input | 32 | Second operand, and the source for the sign operations |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| result | output | 32 | Sign-operation result, zero for compares |
| cc | output | 2 | Condition code for condition set zero |
| cc_we | output | 1 | Write enable for status bits 11:10 |
| exc_flags | output | 5 | Exception flags, invalid at bit 4 |

## Verification
A wrong ordering decision inside the unit shows up as a wrong `cc` on the very cycle after the operands are accepted. The risky cases are the sign-magnitude inversion for negative operands and the treatment of signed zeros. A faulty NaN or signalling-NaN test appears instead as a missing or spurious bit 4 of `exc_flags`, or as a `cc_we` pulse that comes with a sign operation. Since `cc` must hold between compares, a stray update made on a non-compare cycle can be seen at the ports straight away, and it is not hidden until the next compare.

// File: rtl/sp_cmp_sign_unit.sv
module sp_cmp_sign_unit #(
  parameter int W = 32,
  parameter int EXP_W = 8,
  parameter int FLAG_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        op_sel,
  input  logic [W-1:0]      src_a,
  input  logic [W-1:0]      src_b,
  output logic              out_valid,
  output logic [W-1:0]      result,
  output logic [1:0]        cc,
  output logic              cc_we,
  output logic [FLAG_W-1:0] exc_flags
);
  localparam int FRAC_W = W - 1 - EXP_W;
  localparam int SIGN = W - 1;
  localparam int QBIT = FRAC_W - 1;
  localparam logic [2:0] OP_CMPQ = 3'd0;
  localparam logic [2:0] OP_CMPS = 3'd1;
  localparam logic [2:0] OP_MOV  = 3'd2;
  localparam logic [2:0] OP_NEG  = 3'd3;
  localparam logic [2:0] OP_ABS  = 3'd4;
  localparam logic [FLAG_W-1:0] FLAG_INV = FLAG_W'(1) << (FLAG_W - 1);
  localparam logic [W-1:0] SIGN_MASK = {1'b1, {(W-1){1'b0}}};

  logic a_nan, b_nan, a_snan, b_snan, unord, both_zero, mag_lt, is_cmp, raise_inv;
  logic [1:0] cc_n;
  logic [W-1:0] res_n;

  assign a_nan  = (&src_a[SIGN-1:FRAC_W]) & (|src_a[FRAC_W-1:0]);
  assign b_nan  = (&src_b[SIGN-1:FRAC_W]) & (|src_b[FRAC_W-1:0]);
  assign a_snan = a_nan & ~src_a[QBIT];
  assign b_snan = b_nan & ~src_b[QBIT];
  assign unord  = a_nan | b_nan;
  assign both_zero = ~(|src_a[SIGN-1:0]) & ~(|src_b[SIGN-1:0]);
  assign mag_lt = src_a[SIGN-1:0] < src_b[SIGN-1:0];
  assign is_cmp = (op_sel == OP_CMPQ) || (op_sel == OP_CMPS);
  assign raise_inv = unord & ((op_sel == OP_CMPS) | a_snan | b_snan);

  always_comb begin
    if (unord)                          cc_n = 2'd3;
    else if (both_zero || src_a == src_b) cc_n = 2'd0;
    else if (src_a[SIGN] != src_b[SIGN]) cc_n = src_a[SIGN] ? 2'd1 : 2'd2;
    else                                cc_n = (mag_lt ^ src_a[SIGN]) ? 2'd1 : 2'd2;
  end

  always_comb begin
    case (op_sel)
      OP_MOV:  res_n = src_b;
      OP_NEG:  res_n = src_b ^ SIGN_MASK;
      OP_ABS:  res_n = src_b & ~SIGN_MASK;
      default: res_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      cc        <= '0;
      cc_we     <= 1'b0;
      exc_flags <= '0;
    end else begin
      out_valid <= in_valid;
      cc_we     <= in_valid & is_cmp;
      exc_flags <= (in_valid & is_cmp & raise_inv) ? FLAG_INV : '0;
      if (in_valid) result <= res_n;
      if (in_valid && is_cmp) cc <= cc_n;
    end
  end
endmodule

// File: rtl/sp_cmp_sign_unit_chk.sv
module sp_cmp_sign_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [2:0]  op_sel,
  input logic [31:0] src_a,
  input logic [31:0] src_b,
  input logic        out_valid,
  input logic [31:0] result,
  input logic [1:0]  cc,
  input logic        cc_we,
  input logic [4:0]  exc_flags
);
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !cc_we && exc_flags == 5'd0));
  assert_cmp_writes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel <= 3'd1) |=> (cc_we && result == 32'd0));
  assert_low_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(exc_flags[3:0]) == 0);
  assert_flag_unordered_R7: assert property (@(posedge clk) disable iff (!rst_n)
    exc_flags[4] |-> (cc_we && cc == 2'd3));
  assert_neg_flips_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 3'd3) |=> result == ($past(src_b) ^ 32'h8000_0000));
  assert_sign_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel >= 3'd2) |=> (!cc_we && exc_flags == 5'd0));
  assert_cc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cc_we |-> cc == $past(cc));
endmodule

bind sp_cmp_sign_unit sp_cmp_sign_unit_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
  .src_a(src_a), .src_b(src_b), .out_valid(out_valid), .result(result),
  .cc(cc), .cc_we(cc_we), .exc_flags(exc_flags)
);

// File: tb/sp_cmp_sign_unit_test.sv
module sp_cmp_sign_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [2:0] op_sel = 3'd0;
  logic [31:0] src_a = 32'd0, src_b = 32'd0;
  logic out_valid, cc_we;
  logic [31:0] result;
  logic [1:0] cc;
  logic [4:0] exc_flags;

  int checks = 0, errors = 0;
  bit e_valid = 0, e_we = 0;
  bit [31:0] e_res = 0;
  bit [1:0] e_cc = 0;
  bit [4:0] e_flags = 0;
  string cur_tag = "R1";

  always #10 clk = ~clk;

  sp_cmp_sign_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .src_a(src_a), .src_b(src_b), .out_valid(out_valid), .result(result),
    .cc(cc), .cc_we(cc_we), .exc_flags(exc_flags));

  function automatic bit is_nan(bit [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 0);
  endfunction

  function automatic longint rank(bit [31:0] x);
    longint m = longint'(x[30:0]);
    return x[31] ? -m : m;
  endfunction

  task automatic compare(string tag);
    checks++;
    if (out_valid !== e_valid || result !== e_res || cc !== e_cc ||
        cc_we !== e_we || exc_flags !== e_flags) begin
      errors++;
      $display("FAIL %s: got v=%0b res=%h cc=%0d we=%0b fl=%b exp v=%0b res=%h cc=%0d we=%0b fl=%b",
               tag, out_valid, result, cc, cc_we, exc_flags,
               e_valid, e_res, e_cc, e_we, e_flags);
    end
  endtask

  task automatic step(bit v, bit [2:0] op, bit [31:0] a, bit [31:0] b, string tag);
    bit unord, sn;
    @(negedge clk);
    compare(cur_tag);
    in_valid = v; op_sel = op; src_a = a; src_b = b;
    cur_tag = tag;
    e_valid = v;
    e_we = 0;
    e_flags = 0;
    if (v) begin
      if (op <= 1) begin
        unord = is_nan(a) || is_nan(b);
        sn = (is_nan(a) && !a[22]) || (is_nan(b) && !b[22]);
        e_we = 1;
        e_res = 0;
        if (unord) e_cc = 3;
        else if (rank(a) == rank(b)) e_cc = 0;
        else if (rank(a) < rank(b)) e_cc = 1;
        else e_cc = 2;
        if (unord && (op == 1 || sn)) e_flags = 5'b10000;
      end else if (op == 2) e_res = b;
      else if (op == 3) e_res = {~b[31], b[30:0]};
      else if (op == 4) e_res = {1'b0, b[30:0]};
      else e_res = 0;
    end
  endtask

  localparam bit [31:0] PZ = 32'h0000_0000, NZ = 32'h8000_0000;
  localparam bit [31:0] ONE = 32'h3F80_0000, TWO = 32'h4000_0000;
  localparam bit [31:0] M1 = 32'hBF80_0000, M2 = 32'hC000_0000;
  localparam bit [31:0] QNAN = 32'h7FC0_0001, SNAN = 32'h7F80_0001, NSNAN = 32'hFFA0_0000;
  localparam bit [31:0] INF = 32'h7F80_0000;

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: got hang exp completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) begin @(negedge clk); compare("R1"); end
    rst_n = 1'b1;
    step(0, 0, 0, 0, "R1");
    step(1, 0, ONE, ONE, "R3");
    step(1, 0, ONE, TWO, "R3");
    step(1, 0, TWO, ONE, "R3");
    step(1, 0, INF, TWO, "R3");
    step(1, 0, PZ, NZ, "R4");
    step(1, 1, NZ, PZ, "R4");
    step(1, 0, NZ, NZ, "R4");
    step(1, 0, M1, M2, "R5");
    step(1, 0, M2, M1, "R5");
    step(1, 0, M1, ONE, "R5");
    step(1, 0, ONE, NZ, "R5");
    step(1, 0, QNAN, ONE, "R6");
    step(1, 0, ONE, QNAN, "R6");
    step(1, 0, SNAN, ONE, "R7");
    step(1, 0, ONE, NSNAN, "R7");
    step(1, 0, QNAN, QNAN, "R7");
    step(1, 1, QNAN, QNAN, "R8");
    step(1, 1, ONE, QNAN, "R8");
    step(1, 2, ONE, M2, "R9");
    step(1, 3, ONE, M2, "R9");
    step(1, 4, ONE, M2, "R9");
    step(1, 3, SNAN, NSNAN, "R10");
    step(1, 4, QNAN, SNAN, "R10");
    step(1, 2, SNAN, QNAN, "R10");
    step(0, 1, QNAN, QNAN, "R2");
    step(1, 5, ONE, TWO, "R11");
    step(1, 7, QNAN, QNAN, "R11");
    step(0, 2, ONE, ONE, "R2");
    for (int i = 0; i < 400; i++) begin
      bit [31:0] a = $urandom, b = $urandom;
      if (i % 4 == 1) b = a;
      if (i % 4 == 2) b = {~a[31], a[30:0]};
      step(($urandom % 5) != 0, 3'($urandom % 6), a, b, "R3");
    end
    step(0, 0, 0, 0, "R2");
    step(0, 0, 0, 0, "R2");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule